// File: doc/BRIEF.md
# Request-Driven Single-Channel Byte Mover

This block is one channel of a direct memory access engine. It moves bytes between a memory port and a single peripheral data location. Each peripheral request moves one byte: one read from the source side and one write to the destination side. Software first loads the channel's settings through a small write port. These are the peripheral address, the starting buffer address, the byte count, and a control word holding direction, priority and two interrupt enables. Software then sets the enable bit.

While the channel runs, the buffer address steps up by one after every byte and the peripheral address stays fixed. The remaining count steps down by one. The channel raises a sticky half-way flag and a sticky completion flag. It also gives two single-cycle strobes: one when a single byte is left, and one when the last byte has moved. On completion the channel disables itself and ignores any further requests. While the channel is enabled or a transfer is in flight, its settings are locked.

Top module: `xfer_channel`

## Requirements
- R1: After reset, no port request is raised, `ack`, `active`, both flags, both strobes and `irq` are low, and `prio` is 0.
- R2: No transfer starts while the channel is not enabled, even if `req` is held high.
- R3: With direction 0 (control bit 0 clear), each byte is read from memory (`mem_write`=0) and then written to the peripheral with the same value. With direction 1, it is read from the peripheral and then written to memory (`mem_write`=1).
- R4: Every peripheral access uses the programmed peripheral address. The k-th memory access of a run (counting from 0) uses the programmed buffer address plus k.
- R5: A run of N bytes performs exactly N accesses on each port and then drops `active`. Requests made after that get no `ack` and cause no access.
- R6: `half_flag` sets in the cycle after the transfer that leaves floor(N/2) bytes remaining. It stays set until the next enable write. For N=1 it therefore sets together with `done_flag`.
- R7: `eot` is high for exactly one cycle, in the cycle after the final transfer, when `done_flag` also sets. `last` is high for one cycle after the transfer that leaves exactly one byte, which happens only when N≥2.
- R8: `irq` is high when (`half_flag` and half-enable, control bit 1) or (`done_flag` and full-enable, control bit 2) holds.
- R9: While the channel is enabled, writes to the peripheral address (select 0), buffer address (select 1), count (select 2) and control word (select 3) are ignored.
- R10: An enable write (select 4, bit 0) with a count of 0 leaves `active` low, moves no data and raises no flag.
- R11: A port request stays raised with a stable address until its `ready` is seen, and the memory and peripheral ports are never requested in the same cycle.
- R12: `prio` shows control bits 4:3 as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | 3 | Setting select: 0 periph addr, 1 buffer addr, 2 count, 3 control, 4 enable |
| cfg_wdata | input | AW | Setting write data |
| req | input | 1 | Peripheral transfer request (level) |
| ack | output | 1 | One-cycle pulse, request serviced |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, taken with ready |
| mem_ready | input | 1 | Memory access completes this cycle |
| per_valid | output | 1 | Peripheral access request |
| per_write | output | 1 | Peripheral access is a write |
| per_addr | output | AW | Peripheral data address |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data, taken with ready |
| per_ready | input | 1 | Peripheral access completes this cycle |
| prio | output | 2 | Channel priority level for an external arbiter |
| active | output | 1 | Channel enabled |
| half_flag | output | 1 | Sticky half-way flag |
| done_flag | output | 1 | Sticky completion flag |
| eot | output | 1 | End-of-transfer strobe |
| last | output | 1 | One-byte-remaining strobe |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a settings write that arrives while the channel is enabled, between two transfers. The bench creates that gap itself: it holds `req` low after an `ack`, writes new addresses, a new count and a new control word, then goes on requesting. It then checks that addresses, direction, byte total and `prio` are unchanged. The ready inputs stall at random, so each port request must be held over several cycles. Count values of 1 and 2 are run on purpose, since there the half-way, one-left and completion events fall into the same cycle or into neighbouring cycles.

// File: rtl/xfer_pkg.sv
// Package: shared types and select codes for the byte-mover channel.
// Assumes: settings select is 3 bits wide; control word occupies bits 4:0.
package xfer_pkg;

    // Transfer engine sequence states.
    typedef enum logic [1:0] {
        XS_IDLE,
        XS_READ,
        XS_WRITE,
        XS_STEP
    } xs_t;

    // Settings select codes.
    localparam logic [2:0] SEL_PADDR  = 3'd0;
    localparam logic [2:0] SEL_MADDR  = 3'd1;
    localparam logic [2:0] SEL_COUNT  = 3'd2;
    localparam logic [2:0] SEL_CTRL   = 3'd3;
    localparam logic [2:0] SEL_ENABLE = 3'd4;

    // Control word; bit 0 is dir, bit 1 half-enable, bit 2 full-enable, 4:3 priority.
    typedef struct packed {
        logic [1:0] prio;
        logic       full_ie;
        logic       half_ie;
        logic       dir;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

endpackage

// File: rtl/xfer_cfg.sv
// Module: settings holder. Keeps peripheral address, running buffer address,
// control word and enable bit. Writes other than enable are dropped while the
// channel is enabled or a transfer is in flight.
// Assumes: step and finish come from the engine/counter in the same cycle.
module xfer_cfg
    import xfer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             engine_busy,
    input  logic             cnt_zero,
    input  logic             step,
    input  logic             finish,
    output logic [AW-1:0]    paddr,
    output logic [AW-1:0]    maddr,
    output chan_ctrl_t       ctrl,
    output logic             en,
    output logic             count_we,
    output logic             start
);

    logic locked;
    logic wr_paddr;
    logic wr_maddr;
    logic wr_ctrl;
    logic wr_enable;

    // Decode which setting a write targets and whether it is accepted.
    always_comb begin
        locked    = en | engine_busy;
        wr_paddr  = cfg_we && (cfg_sel == SEL_PADDR) && !locked;
        wr_maddr  = cfg_we && (cfg_sel == SEL_MADDR) && !locked;
        wr_ctrl   = cfg_we && (cfg_sel == SEL_CTRL)  && !locked;
        count_we  = cfg_we && (cfg_sel == SEL_COUNT) && !locked;
        wr_enable = cfg_we && (cfg_sel == SEL_ENABLE);
        start     = wr_enable && cfg_wdata[0];
    end

    // Fixed peripheral address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr <= '0;
        end else if (wr_paddr) begin
            paddr <= cfg_wdata;
        end
    end

    // Buffer address: loaded by software, stepped by one per byte moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maddr <= '0;
        end else if (wr_maddr) begin
            maddr <= cfg_wdata;
        end else if (step) begin
            maddr <= maddr + AW'(1);
        end
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        end
    end

    // Enable bit: cleared on completion, refused when count is zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (finish) begin
            en <= 1'b0;
        end else if (wr_enable) begin
            en <= cfg_wdata[0] && !cnt_zero;
        end
    end

endmodule

// File: rtl/xfer_count.sv
// Module: remaining-count tracker. Loads the byte total, steps down once per
// transfer and produces the sticky half/done flags and the one-left and
// end strobes.
// Assumes: step never arrives while the count is zero.
module xfer_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_we,
    input  logic [CW-1:0] load_val,
    input  logic          start,
    input  logic          step,
    output logic          cnt_zero,
    output logic          finish,
    output logic          half_flag,
    output logic          done_flag,
    output logic          eot,
    output logic          last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] remaining;
    logic [CW-1:0] loaded;
    logic [CW-1:0] half_mark;
    logic [CW-1:0] nxt;

    // Derived values: next count, half threshold, zero and final-step detection.
    always_comb begin
        nxt       = remaining - ONE;
        half_mark = loaded >> 1;
        cnt_zero  = (remaining == '0);
        finish    = step && (remaining == ONE);
    end

    // Count registers: software load or one step per serviced request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            loaded    <= '0;
        end else if (load_we) begin
            remaining <= load_val;
            loaded    <= load_val;
        end else if (step && !cnt_zero) begin
            remaining <= nxt;
        end
    end

    // Sticky flags: cleared by an enable write, set by count milestones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_flag <= 1'b0;
            done_flag <= 1'b0;
        end else if (start) begin
            half_flag <= 1'b0;
            done_flag <= 1'b0;
        end else if (step && !cnt_zero) begin
            if (nxt == half_mark) begin
                half_flag <= 1'b1;
            end
            if (nxt == '0) begin
                done_flag <= 1'b1;
            end
        end
    end

    // Single-cycle strobes for one-left and end of transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eot  <= 1'b0;
            last <= 1'b0;
        end else begin
            eot  <= step && !cnt_zero && (nxt == '0);
            last <= step && !cnt_zero && (nxt == ONE);
        end
    end

endmodule

// File: rtl/xfer_engine.sv
// Module: transfer sequencer. For each accepted request, reads one byte from
// the source port, writes it to the destination port, then pulses ack/step.
// Assumes: ports complete an access in the cycle ready is high while valid.
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cnt_zero,
    input  logic          req,
    input  logic          dir,
    input  logic [AW-1:0] maddr,
    input  logic [AW-1:0] paddr,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          per_valid,
    output logic          per_write,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    input  logic [DW-1:0] per_rdata,
    input  logic          per_ready,
    output logic          ack,
    output logic          step,
    output logic          busy
);

    xs_t           state;
    logic [DW-1:0] dbuf;
    logic          src_ready;
    logic          dst_ready;
    logic [DW-1:0] src_data;

    // Route ready/data from source and destination according to direction.
    always_comb begin
        src_ready = dir ? per_ready : mem_ready;
        dst_ready = dir ? mem_ready : per_ready;
        src_data  = dir ? per_rdata : mem_rdata;
    end

    // Port request outputs derived from the current phase.
    always_comb begin
        mem_valid = ((state == XS_READ) && !dir) || ((state == XS_WRITE) && dir);
        per_valid = ((state == XS_READ) && dir)  || ((state == XS_WRITE) && !dir);
        mem_write = (state == XS_WRITE);
        per_write = (state == XS_WRITE);
        mem_addr  = maddr;
        per_addr  = paddr;
        mem_wdata = dbuf;
        per_wdata = dbuf;
        ack       = (state == XS_STEP);
        step      = (state == XS_STEP);
        busy      = (state != XS_IDLE);
    end

    // Phase sequencing: idle -> read -> write -> step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XS_IDLE;
        end else begin
            case (state)
                XS_IDLE:  if (en && !cnt_zero && req) state <= XS_READ;
                XS_READ:  if (src_ready) state <= XS_WRITE;
                XS_WRITE: if (dst_ready) state <= XS_STEP;
                default:  state <= XS_IDLE;
            endcase
        end
    end

    // Byte holding register captured at the end of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbuf <= '0;
        end else if ((state == XS_READ) && src_ready) begin
            dbuf <= src_data;
        end
    end

endmodule

// File: rtl/xfer_channel.sv
// Module: top of the request-driven byte-mover channel. Ties the settings
// holder, the count tracker and the sequencer together and forms the irq.
// Assumes: one channel only; arbitration is outside.
module xfer_channel
    import xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req,
    output logic          ack,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          per_valid,
    output logic          per_write,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    input  logic [DW-1:0] per_rdata,
    input  logic          per_ready,
    output logic [1:0]    prio,
    output logic          active,
    output logic          half_flag,
    output logic          done_flag,
    output logic          eot,
    output logic          last,
    output logic          irq
);

    logic [AW-1:0] paddr;
    logic [AW-1:0] maddr;
    chan_ctrl_t    ctrl;
    logic          en;
    logic          count_we;
    logic          start;
    logic          cnt_zero;
    logic          finish;
    logic          step;
    logic          busy;

    xfer_cfg #(.AW(AW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .engine_busy (busy),
        .cnt_zero    (cnt_zero),
        .step        (step),
        .finish      (finish),
        .paddr       (paddr),
        .maddr       (maddr),
        .ctrl        (ctrl),
        .en          (en),
        .count_we    (count_we),
        .start       (start)
    );

    xfer_count #(.CW(CW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (count_we),
        .load_val  (cfg_wdata[CW-1:0]),
        .start     (start),
        .step      (step),
        .cnt_zero  (cnt_zero),
        .finish    (finish),
        .half_flag (half_flag),
        .done_flag (done_flag),
        .eot       (eot),
        .last      (last)
    );

    xfer_engine #(.AW(AW), .DW(DW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cnt_zero  (cnt_zero),
        .req       (req),
        .dir       (ctrl.dir),
        .maddr     (maddr),
        .paddr     (paddr),
        .mem_valid (mem_valid),
        .mem_write (mem_write),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .per_valid (per_valid),
        .per_write (per_write),
        .per_addr  (per_addr),
        .per_wdata (per_wdata),
        .per_rdata (per_rdata),
        .per_ready (per_ready),
        .ack       (ack),
        .step      (step),
        .busy      (busy)
    );

    // Status outputs and interrupt combination.
    always_comb begin
        prio   = ctrl.prio;
        active = en;
        irq    = (half_flag && ctrl.half_ie) || (done_flag && ctrl.full_ie);
    end

endmodule

// File: rtl/xfer_channel_chk.sv
// Module: protocol checker bound to the channel top.
// Assumes: observed through top-level ports only.
module xfer_channel_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready,
    input logic          per_valid,
    input logic [AW-1:0] per_addr,
    input logic          per_ready,
    input logic          active,
    input logic          done_flag,
    input logic          eot,
    input logic          last
);

    // R11
    ports_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && per_valid));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    // R11
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_valid && !per_ready) |=> (per_valid && $stable(per_addr)));

    // R4
    paddr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(per_addr));

    // R7
    eot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot |=> !eot);

    // R7
    eot_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot |-> (done_flag && !active));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eot, last}));

    // R5
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> (!mem_valid && !per_valid));

endmodule

bind xfer_channel xfer_channel_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .per_valid (per_valid),
    .per_addr  (per_addr),
    .per_ready (per_ready),
    .active    (active),
    .done_flag (done_flag),
    .eot       (eot),
    .last      (last)
);

// File: tb/xfer_channel_test.sv
`timescale 1ns/1ps
module xfer_channel_test;

    localparam int AW = 32;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req = 1'b0;
    logic          ack;
    logic          mem_valid, mem_write, per_valid, per_write;
    logic [AW-1:0] mem_addr, per_addr;
    logic [DW-1:0] mem_wdata, per_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] per_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          per_ready = 1'b0;
    logic [1:0]    prio;
    logic          active, half_flag, done_flag, eot, last, irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0]    mem_model [256];
    logic [7:0]    per_log   [256];
    logic [7:0]    src_copy  [256];
    logic [AW-1:0] exp_mbase = '0;
    logic [AW-1:0] exp_paddr = '0;
    int            mem_idx = 0;
    int            per_idx = 0;
    bit            run_dir = 1'b0;
    int            salt = 0;
    bit            monitor_on = 1'b0;

    always #10 clk = ~clk;

    xfer_channel #(.AW(AW), .DW(DW), .CW(16)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req(req), .ack(ack),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .per_valid(per_valid), .per_write(per_write), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .per_ready(per_ready),
        .prio(prio), .active(active), .half_flag(half_flag),
        .done_flag(done_flag), .eot(eot), .last(last), .irq(irq)
    );

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] per_src(input int k, input int s);
        return 8'(k * 29 + s * 7 + 3);
    endfunction

    // Port responders: random ready, models completed at the next posedge.
    initial begin
        forever begin
            @(negedge clk);
            mem_ready = mem_valid && ($urandom_range(0, 2) != 0);
            per_ready = per_valid && ($urandom_range(0, 2) != 0);
            if (monitor_on && mem_valid && mem_ready) begin
                chk("R4", "memory address", mem_addr, exp_mbase + AW'(mem_idx));
                chk("R3", "memory write direction", mem_write, run_dir);
                if (mem_write) mem_model[mem_addr[7:0]] = mem_wdata;
                else mem_rdata = mem_model[mem_addr[7:0]];
                mem_idx++;
            end
            if (monitor_on && per_valid && per_ready) begin
                chk("R4", "peripheral address", per_addr, exp_paddr);
                chk("R3", "peripheral write direction", per_write, !run_dir);
                if (per_write) per_log[per_idx[7:0]] = per_wdata;
                else per_rdata = per_src(per_idx, salt);
                per_idx++;
            end
        end
    end

    task automatic cfg_write(input logic [2:0] sel, input logic [AW-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_request(output bit got);
        got = 1'b0;
        req = 1'b1;
        for (int t = 0; t < 300 && !got; t++) begin
            @(negedge clk);
            if (ack) got = 1'b1;
        end
        req = 1'b0;
    endtask

    task automatic hold_request_idle(input string tag, input int cycles);
        int m0, p0, acks;
        m0 = mem_idx; p0 = per_idx; acks = 0;
        req = 1'b1;
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk);
            if (ack) acks++;
        end
        req = 1'b0;
        chk(tag, "acks for ignored requests", acks, 0);
        chk(tag, "memory accesses for ignored requests", mem_idx - m0, 0);
        chk(tag, "peripheral accesses for ignored requests", per_idx - p0, 0);
    endtask

    task automatic run_case(input bit d, input int n, input bit hie, input bit fie,
                            input logic [1:0] pr, input logic [AW-1:0] mb,
                            input logic [AW-1:0] pb);
        bit got;
        int half_at;
        salt++;
        run_dir = d; exp_mbase = mb; exp_paddr = pb;
        mem_idx = 0; per_idx = 0;
        for (int i = 0; i < n; i++) begin
            src_copy[i] = 8'($urandom);
            mem_model[8'(mb + AW'(i))] = src_copy[i];
        end
        cfg_write(3'd0, pb);
        cfg_write(3'd1, mb);
        cfg_write(3'd2, AW'(n));
        cfg_write(3'd3, AW'({pr, fie, hie, d}));
        cfg_write(3'd4, AW'(1));
        chk("R12", "priority output", prio, pr);
        chk("R2", "active after enable", active, 1);
        half_at = n - n / 2;
        for (int k = 1; k <= n; k++) begin
            do_request(got);
            chk("R5", "request serviced", got, 1);
            if (!got) break;
            @(negedge clk);
            chk("R6", "half flag", half_flag, k >= half_at);
            chk("R5", "done flag", done_flag, k == n);
            chk("R7", "end strobe", eot, k == n);
            chk("R7", "one-left strobe", last, (n >= 2) && (k == n - 1));
            chk("R8", "irq", irq, ((k >= half_at) && hie) || ((k == n) && fie));
            if (k == 1 && n > 2) begin
                // R9: settings writes while enabled must be dropped
                cfg_write(3'd0, ~pb);
                cfg_write(3'd1, mb + AW'(100));
                cfg_write(3'd2, AW'(2));
                cfg_write(3'd3, AW'({~pr, fie, hie, ~d}));
                chk("R9", "priority unchanged while enabled", prio, pr);
                chk("R9", "still active", active, 1);
            end
        end
        chk("R5", "memory access total", mem_idx, n);
        chk("R5", "peripheral access total", per_idx, n);
        chk("R5", "inactive after run", active, 0);
        for (int i = 0; i < n; i++) begin
            if (d == 1'b0) chk("R3", "byte at peripheral", per_log[i], src_copy[i]);
            else chk("R3", "byte in memory", mem_model[8'(mb + AW'(i))], per_src(i, salt));
        end
        hold_request_idle("R5", 20);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin
            mem_model[i] = '0;
            per_log[i] = '0;
            src_copy[i] = '0;
        end
        repeat (4) @(negedge clk);
        chk("R1", "mem_valid in reset", mem_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mem_valid", mem_valid, 0);
        chk("R1", "per_valid", per_valid, 0);
        chk("R1", "ack", ack, 0);
        chk("R1", "active", active, 0);
        chk("R1", "flags", {half_flag, done_flag}, 0);
        chk("R1", "strobes", {eot, last}, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "prio", prio, 0);
        monitor_on = 1'b1;

        // R2: programmed but not enabled
        cfg_write(3'd0, 32'h4000_0010);
        cfg_write(3'd1, 32'h0000_0020);
        cfg_write(3'd2, 32'd5);
        hold_request_idle("R2", 15);

        // Directed corner counts
        run_case(1'b0, 1, 1'b1, 1'b1, 2'd3, 32'h0000_0010, 32'h4000_0004);
        run_case(1'b1, 2, 1'b1, 1'b0, 2'd1, 32'h0000_00F0, 32'h4000_0008);
        run_case(1'b0, 3, 1'b0, 1'b1, 2'd2, 32'h0000_00FE, 32'h4000_000C);
        run_case(1'b1, 7, 1'b1, 1'b1, 2'd0, 32'h1000_0040, 32'h4001_0000);

        // R10: zero count
        cfg_write(3'd2, 32'd0);
        cfg_write(3'd4, 32'd1);
        chk("R10", "active with zero count", active, 0);
        hold_request_idle("R10", 15);
        chk("R10", "half flag with zero count", half_flag, 0);
        chk("R10", "done flag with zero count", done_flag, 0);

        // Random runs
        for (int r = 0; r < 10; r++) begin
            run_case(1'($urandom), int'($urandom_range(1, 24)), 1'($urandom),
                     1'($urandom), 2'($urandom), AW'($urandom),
                     AW'($urandom));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule